// File: doc/BRIEF.md
# Button Auto-Repeat Event Generator

This block sits between a set of already-debounced button levels and the logic that acts on key presses. Software-style navigation needs a single event when a key goes down. It also needs a steady stream of further events when the key stays down, the way a keyboard repeats. The block samples the held-button vector only when a poll strobe is high. It keeps one signed hold counter per button and turns the counter values into one-cycle event pulses.

A counter rests at -1 while its button is released. Each poll that sees the button held moves the counter up by one. An event fires whenever the new count is 0, so the first held poll always produces a press. After that the button stays quiet until the count reaches the long-hold delay, 30 polls by default. From then on it fires every time the count is a multiple of the repeat period, 6 by default. The event vector is registered and is valid only in the cycle that follows the poll strobe.

The default build handles six buttons. Bit 0 is up, bit 1 down, bit 2 left, bit 3 right, bit 4 select and bit 5 back. The delay, the repeat period and the counter width are parameters.

Top module: `key_repeat_gen`

## Requirements
- R1: While reset is asserted, every bit of event_o is 0 and every hold counter is at idle (-1), so the first poll that sees a button held after reset produces an event for it.
- R2: A poll that finds a button held while its counter is idle (the first poll after a release) raises that button's event bit.
- R3: On a continuous hold, each poll moves the counter up by one, and no event appears for counts 1 to 29 (with the default delay of 30).
- R4: On a continuous hold, an event fires at every count that is at least the delay (30) and a multiple of the period (6), so the events come at held polls 0, 30, 36, 42, 48, 54 and so on.
- R5: A poll that finds a button released returns its counter to -1 and produces no event for it. The next held poll then fires at once.
- R6: Between poll strobes the counters do not change, whatever the button inputs do.
- R7: event_o is 0 in every cycle that does not directly follow a poll strobe. An event therefore lasts exactly one cycle.
- R8: Buttons are independent. Bit k of held_i drives only bit k of event_o (bit 0 up, 1 down, 2 left, 3 right, 4 select, 5 back).
- R9: A hold longer than the counter range does not wrap around. At the top of its range the counter steps back by one period, which keeps its phase, so events continue every 6 polls for as long as the button is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| poll_i | input | 1 | Poll strobe; button levels are sampled when high |
| held_i | input | NUM_KEYS | Held level per button, 1 = pressed |
| event_o | output | NUM_KEYS | One-cycle press/repeat events, valid the cycle after poll_i |

## Verification
The assertions assume that held_i is meaningful only while poll_i is high. They place no demand on its value between strobes. They also assume that poll_i may stay high on consecutive cycles without harm, because each strobe counts as its own poll. The stimulus deliberately drives pseudo-random levels onto held_i between strobes, so the checks on R6 and R7 face inputs that would break a design which samples outside the poll. Strobes are spaced a few cycles apart, so each event pulse and its return to zero can both be seen.

// File: rtl/key_repeat_pkg.sv
package key_repeat_pkg;

  // Bit positions of the buttons in held_i / event_o
  typedef enum int unsigned {
    K_UP     = 0,
    K_DOWN   = 1,
    K_LEFT   = 2,
    K_RIGHT  = 3,
    K_SELECT = 4,
    K_BACK   = 5,
    K_COUNT  = 6
  } key_id_e;

  localparam int unsigned KEYS = K_COUNT;

endpackage

// File: rtl/key_hold_tracker.sv
module key_hold_tracker #(
  parameter int CNT_W       = 8,
  parameter int FIRST_DELAY = 30,
  parameter int PERIOD      = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    poll_i,
  input  logic                    held_i,
  output logic signed [CNT_W-1:0] count_o,
  output logic                    fire_o
);

  localparam int CNT_MAX = (1 << (CNT_W - 1)) - 1;
  localparam logic signed [CNT_W-1:0] IDLE_V = '1;
  localparam logic signed [CNT_W-1:0] ONE_V  = CNT_W'(1);
  localparam logic signed [CNT_W-1:0] MAX_V  = CNT_W'(CNT_MAX);
  localparam logic signed [CNT_W-1:0] WRAP_V = CNT_W'(CNT_MAX + 1 - PERIOD);

  // Count after one poll: released -> idle, held -> +1, folded back by one period at the top
  function automatic logic signed [CNT_W-1:0] advance(
    input logic signed [CNT_W-1:0] c, input logic held);
    int v;
    if (!held) begin
      v = -1;
    end else begin
      v = int'(c) + 1;
      if (v > CNT_MAX) v = v - PERIOD;
    end
    return CNT_W'(v);
  endfunction

  // Firing rule for a freshly advanced count
  function automatic logic fires(input logic signed [CNT_W-1:0] c);
    int v;
    v = int'(c);
    return (v == 0) || ((v >= FIRST_DELAY) && ((v % PERIOD) == 0));
  endfunction

  logic signed [CNT_W-1:0] count_q;
  logic signed [CNT_W-1:0] count_d;

  assign count_d = advance(count_q, held_i);
  assign fire_o  = poll_i && fires(count_d);
  assign count_o = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= IDLE_V;
    else if (poll_i) count_q <= count_d;
  end

  // R5
  released_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_i && !held_i |=> count_q == IDLE_V);

  // R6
  between_polls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_i |=> $stable(count_q));

  // R3
  hold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_i && held_i && (count_q != MAX_V) |=> count_q == $past(count_q) + ONE_V);

  // R9
  top_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_i && held_i && (count_q == MAX_V) |=> count_q == WRAP_V);

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q >= IDLE_V);

endmodule

// File: rtl/key_event_reg.sv
module key_event_reg #(
  parameter int NUM_KEYS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                poll_i,
  input  logic [NUM_KEYS-1:0] fire_i,
  output logic [NUM_KEYS-1:0] event_o
);

  logic [NUM_KEYS-1:0] event_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      event_q <= '0;
    else if (poll_i) event_q <= fire_i;
    else             event_q <= '0;
  end

  assign event_o = event_q;

  // R7
  quiet_off_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_i |=> event_o == '0);

endmodule

// File: rtl/key_repeat_gen.sv
module key_repeat_gen
  import key_repeat_pkg::*;
#(
  parameter int NUM_KEYS    = KEYS,
  parameter int CNT_W       = 8,
  parameter int FIRST_DELAY = 30,
  parameter int PERIOD      = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                poll_i,
  input  logic [NUM_KEYS-1:0] held_i,
  output logic [NUM_KEYS-1:0] event_o
);

  localparam logic signed [CNT_W-1:0] IDLE_V = '1;

  logic [NUM_KEYS-1:0]     fire_vec;
  logic signed [CNT_W-1:0] key_cnt [NUM_KEYS];

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    key_hold_tracker #(
      .CNT_W      (CNT_W),
      .FIRST_DELAY(FIRST_DELAY),
      .PERIOD     (PERIOD)
    ) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .poll_i (poll_i),
      .held_i (held_i[k]),
      .count_o(key_cnt[k]),
      .fire_o (fire_vec[k])
    );

    // R2
    first_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_i && held_i[k] && (key_cnt[k] == IDLE_V) |=> event_o[k]);

    // R5
    released_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_i && !held_i[k] |=> !event_o[k]);
  end

  key_event_reg #(.NUM_KEYS(NUM_KEYS)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .poll_i (poll_i),
    .fire_i (fire_vec),
    .event_o(event_o)
  );

endmodule

// File: tb/tb_key_repeat_gen.sv
`timescale 1ns/1ps
module tb_key_repeat_gen;

  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         poll_i = 1'b0;
  logic [N-1:0] held_i = '0;
  logic [N-1:0] event_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  key_repeat_gen dut (
    .clk(clk), .rst_n(rst_n), .poll_i(poll_i), .held_i(held_i), .event_o(event_o)
  );

  always #4 clk = ~clk;  // 125 MHz

  // Behavioural reference: unbounded hold counts, expected events for the next cycle
  int          hold_n [N];
  logic [N-1:0] exp_ev = '0;
  string       exp_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) hold_n[k] = -1;
      exp_ev  <= '0;
      exp_tag <= "R1";
    end else if (poll_i) begin
      logic [N-1:0] e;
      string t;
      e = '0;
      t = "R3";
      for (int k = 0; k < N; k++) begin
        if (held_i[k]) hold_n[k] = hold_n[k] + 1;
        else           hold_n[k] = -1;
        if (hold_n[k] == 0) begin
          e[k] = 1'b1; t = "R2";
        end else if (hold_n[k] >= 30 && hold_n[k] % 6 == 0) begin
          e[k] = 1'b1; t = (hold_n[k] > 120) ? "R9" : "R4";
        end
      end
      exp_ev  <= e;
      exp_tag <= t;
    end else begin
      exp_ev  <= '0;
      exp_tag <= "R7";
    end
  end

  // Comparison on every clock, away from the active edge
  always @(negedge clk) begin
    n_cmp++;
    if (event_o !== exp_ev) begin
      n_bad++;
      $display("FAIL %s cycle %0d: event_o actual %b expected %b", exp_tag, cycles, event_o, exp_ev);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  // One poll, then a read of the event, then a quiet cycle with noise on held_i (R6, R7)
  task automatic do_poll(input logic [N-1:0] h, output logic [N-1:0] ev);
    @(negedge clk);
    held_i = h;
    poll_i = 1'b1;
    @(negedge clk);
    poll_i = 1'b0;
    ev = event_o;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    held_i = lfsr[N-1:0];
    @(negedge clk);
    check(event_o == '0, "R7", int'(event_o), 0);
  endtask

  initial begin
    logic [N-1:0] ev;
    int got[$];
    int want[$];
    int cnt;

    repeat (3) @(negedge clk);
    check(event_o == '0, "R1", int'(event_o), 0);
    rst_n = 1'b1;

    // R1 / R2: first held poll after reset fires
    do_poll(6'b000001, ev);
    check(ev == 6'b000001, "R1", int'(ev), 1);
    do_poll(6'b000000, ev);
    check(ev == '0, "R5", int'(ev), 0);

    // R3 / R4: 60-poll hold on up, events at 0,30,36,42,48,54
    for (int p = 0; p < 60; p++) begin
      do_poll(6'b000001, ev);
      if (ev[0]) got.push_back(p);
    end
    want = '{0, 30, 36, 42, 48, 54};
    check(got.size() == want.size(), "R4", got.size(), want.size());
    for (int i = 0; i < want.size() && i < got.size(); i++)
      check(got[i] == want[i], (i == 0) ? "R3" : "R4", got[i], want[i]);

    // R5: no events after release, immediate event on next press
    cnt = 0;
    for (int p = 0; p < 10; p++) begin
      do_poll(6'b000000, ev);
      if (ev != '0) cnt++;
    end
    check(cnt == 0, "R5", cnt, 0);
    do_poll(6'b000001, ev);
    check(ev == 6'b000001, "R5", int'(ev), 1);
    do_poll(6'b000000, ev);

    // R8: down held 10 polls, then select pressed: only select fires
    for (int p = 0; p < 10; p++) do_poll(6'b000010, ev);
    do_poll(6'b010010, ev);
    check(ev == 6'b010000, "R8", int'(ev), 16);
    for (int p = 0; p < 19; p++) do_poll(6'b010010, ev);
    do_poll(6'b010010, ev);  // down at count 30, select at count 20
    check(ev == 6'b000010, "R8", int'(ev), 2);
    do_poll(6'b000000, ev);

    // R9: 250-poll hold on back: 38 events, no wrap
    cnt = 0;
    for (int p = 0; p < 250; p++) begin
      do_poll(6'b100000, ev);
      if (ev[5]) cnt++;
    end
    check(cnt == 38, "R9", cnt, 38);
    do_poll(6'b000000, ev);

    // R1: reset in the middle of a hold returns the counter to idle
    for (int p = 0; p < 40; p++) do_poll(6'b001000, ev);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(event_o == '0, "R1", int'(event_o), 0);
    rst_n = 1'b1;
    do_poll(6'b001000, ev);
    check(ev == 6'b001000, "R1", int'(ev), 8);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule